// File: doc/BRIEF.md
# Two-Level Round-Robin Bus Arbiter

This block decides which of several masters on a shared parallel bus may drive the next transaction. Each master has its own request line and its own grant line. A configuration bit per master places it in either a high or a low priority class. The high class rotates round-robin. The whole low class shares one extra position in that rotation, and its members rotate among themselves each time that position is served. The grant output is registered and is either one-hot or all zero.

The rotation pointers move only when a granted master actually begins a transaction, which it signals on a transaction-start input. Until then, a grant is pending. It is re-evaluated on every clock, so a higher-priority master that raises its request takes a pending grant away. When the bus is idle and the grant must pass from one master to another, the arbiter drops every grant for one clock. This gives a turnaround cycle before the new winner is granted.

Top module: `two_level_arb`

## Requirements
- R1: A synchronous active-high reset drives all grants to zero on the next clock. Afterwards the high-class search starts at master 0, and the low-class search starts at master index 0, which selects the lowest-indexed low-class master.
- R2: At most one grant bit is high in any cycle.
- R3: In the high class, the master that last started a transaction becomes lowest priority and the next position in the rotation becomes highest. Masters that are not requesting are skipped.
- R4: Bit i of `low_grp` set to 1 puts master i in the low class. The high rotation visits the high-class masters in ascending index order, followed by one low-class position. Low-class masters rotate in ascending index order, and that rotation advances only when the low-class position is served.
- R5: With masters 1 and 3 in the low class, masters 0 to 3 requesting, and master 1 the last to start, the grant order is 0, 2, 3, 0, 2, 1.
- R6: Under the same setup with master 2 not requesting, the grant order is 0, 3, 0, 1, 0, 3.
- R7: With all masters in one class, the order is 0, 1, 2, 3, 4. With only master 2 in the low class, the order is 0, 1, 3, 4, 2.
- R8: The rotation pointers change only in a cycle where `txn_start` is high and a grant is held.
- R9: A pending grant moves on the next clock to a higher-priority master that starts requesting.
- R10: When `bus_idle` is high and the winner differs from the currently held non-zero grant, all grants are zero for one clock and the winner is granted on the clock after. When `bus_idle` is low, the grant moves directly.
- R11: With no request active, the grant is zero on the next clock. The rotation pointers hold, so ordering resumes where it left off.
- R12: A grant is given only to a master whose request was high on the previous clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_MASTERS | Request line, one per master |
| low_grp | input | N_MASTERS | Class select per master, 1 = low class |
| bus_idle | input | 1 | High when no transaction occupies the bus |
| txn_start | input | 1 | Granted master begins its transaction this clock |
| gnt | output | N_MASTERS | Registered grant vector, one-hot or zero |

## Verification
The hardest situation to reach is the withdrawal of a pending grant held by a low-class master. To get there, the low pointer must already have moved past one member, a high-class master must have just started so that the low position is next, and then a high-class master ahead of the low position must raise its request before the pending grant is used. The bench builds this in steps. It first lets master 1 run alone, then lets master 0 start, so that master 3 holds a pending grant. It then raises master 2's request with `txn_start` held low and expects the grant to move to master 2. A behavioural model compares the grant on every clock throughout, including the turnaround cycles driven with `bus_idle` high.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        DEC_IDLE,
        DEC_TURN,
        DEC_WIN
    } grant_dec_e;

    function automatic int unsigned wrap_inc(int unsigned v, int unsigned m);
        return (v + 1 >= m) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/arb_oh_enc.sv
module arb_oh_enc #(
    parameter int unsigned W  = 5,
    parameter int unsigned IW = 3
) (
    input  logic [W-1:0]  oh,
    output logic          vld,
    output logic [IW-1:0] idx
);
    always_comb begin
        vld = |oh;
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (oh[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/arb_grp_split.sv
module arb_grp_split #(
    parameter int unsigned N = 5
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] low_grp,
    output logic [N:0]   slot_req,
    output logic [N-1:0] low_req
);
    assign low_req = req & low_grp;

    for (genvar g = 0; g < N; g++) begin : g_slot
        assign slot_req[g] = req[g] & ~low_grp[g];
    end
    assign slot_req[N] = |low_req;
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int unsigned W  = 6,
    parameter int unsigned PW = 3
) (
    input  logic [W-1:0]  cand,
    input  logic [PW-1:0] start,
    output logic          found,
    output logic [PW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < W; i++) begin
            if (!found && cand[(int'(start) + i) % W]) begin
                found = 1'b1;
                idx   = PW'((int'(start) + i) % W);
            end
        end
    end
endmodule

// File: rtl/two_level_arb.sv
module two_level_arb
    import arb_pkg::*;
#(
    parameter int unsigned N_MASTERS = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_MASTERS-1:0] req,
    input  logic [N_MASTERS-1:0] low_grp,
    input  logic                 bus_idle,
    input  logic                 txn_start,
    output logic [N_MASTERS-1:0] gnt
);
    localparam int unsigned N_SLOTS = N_MASTERS + 1;
    localparam int unsigned HPW     = $clog2(N_SLOTS);
    localparam int unsigned LPW     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;

    typedef struct packed {
        logic [N_MASTERS-1:0] gnt;
        logic [HPW-1:0]       hi_ptr;
        logic [LPW-1:0]       lo_ptr;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic                 owner_vld;
    logic [LPW-1:0]       owner_idx;
    logic                 started;
    logic [HPW-1:0]       hi_eff;
    logic [LPW-1:0]       lo_eff;
    logic [N_MASTERS:0]   slot_req;
    logic [N_MASTERS-1:0] low_req;
    logic                 hi_found, lo_found;
    logic [HPW-1:0]       hi_idx;
    logic [LPW-1:0]       lo_idx;
    logic                 sel_vld;
    logic [LPW-1:0]       sel_idx;
    logic [N_MASTERS-1:0] win;
    grant_dec_e           dec;
    logic [HPW-1:0]       hi_ptr_q;
    logic [LPW-1:0]       lo_ptr_q;

    arb_oh_enc #(.W(N_MASTERS), .IW(LPW)) u_owner (
        .oh  (st_q.gnt),
        .vld (owner_vld),
        .idx (owner_idx)
    );

    // pointer positions after an optional transaction start this clock
    always_comb begin
        started = txn_start && owner_vld;
        hi_eff  = st_q.hi_ptr;
        lo_eff  = st_q.lo_ptr;
        if (started) begin
            if (low_grp[owner_idx]) begin
                hi_eff = '0;
                lo_eff = LPW'(wrap_inc(32'(owner_idx), N_MASTERS));
            end else begin
                hi_eff = HPW'(32'(owner_idx) + 1);
            end
        end
    end

    arb_grp_split #(.N(N_MASTERS)) u_split (
        .req      (req),
        .low_grp  (low_grp),
        .slot_req (slot_req),
        .low_req  (low_req)
    );

    arb_rr_pick #(.W(N_SLOTS), .PW(HPW)) u_hi_pick (
        .cand  (slot_req),
        .start (hi_eff),
        .found (hi_found),
        .idx   (hi_idx)
    );

    arb_rr_pick #(.W(N_MASTERS), .PW(LPW)) u_lo_pick (
        .cand  (low_req),
        .start (lo_eff),
        .found (lo_found),
        .idx   (lo_idx)
    );

    always_comb begin
        sel_vld = 1'b0;
        sel_idx = '0;
        if (hi_found) begin
            if (32'(hi_idx) == N_MASTERS) begin
                sel_vld = lo_found;
                sel_idx = lo_idx;
            end else begin
                sel_vld = 1'b1;
                sel_idx = LPW'(hi_idx);
            end
        end

        for (int i = 0; i < N_MASTERS; i++) begin
            win[i] = sel_vld && (32'(sel_idx) == i);
        end

        if (!sel_vld) begin
            dec = DEC_IDLE;
        end else if (bus_idle && owner_vld && (win != st_q.gnt)) begin
            dec = DEC_TURN;
        end else begin
            dec = DEC_WIN;
        end

        st_d        = st_q;
        st_d.gnt    = (dec == DEC_WIN) ? win : '0;
        st_d.hi_ptr = hi_eff;
        st_d.lo_ptr = lo_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt      = st_q.gnt;
    assign hi_ptr_q = st_q.hi_ptr;
    assign lo_ptr_q = st_q.lo_ptr;

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
    parameter int unsigned N   = 5,
    parameter int unsigned HPW = 3,
    parameter int unsigned LPW = 3
) (
    input logic           clk,
    input logic           rst,
    input logic [N-1:0]   req,
    input logic           bus_idle,
    input logic           txn_start,
    input logic [N-1:0]   gnt,
    input logic [HPW-1:0] hi_ptr,
    input logic [LPW-1:0] lo_ptr
);
    p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    p_gnt_req_r12: assert property (@(posedge clk) disable iff (rst)
        (|gnt) |-> (|(gnt & $past(req))));

    p_turnaround_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_idle) && $past(|gnt) && (|gnt)) |-> (gnt == $past(gnt)));

    p_ptr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(txn_start && (|gnt)) |=> ($stable(hi_ptr) && $stable(lo_ptr)));

    p_no_req_r11: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |=> (gnt == '0));
endmodule

bind two_level_arb arb_checker #(.N(N_MASTERS), .HPW(HPW), .LPW(LPW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .bus_idle  (bus_idle),
    .txn_start (txn_start),
    .gnt       (gnt),
    .hi_ptr    (hi_ptr_q),
    .lo_ptr    (lo_ptr_q)
);

// File: tb/tb_two_level_arb.sv
`timescale 1ns/1ps
module tb_two_level_arb;
    localparam int N = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0;
    logic [N-1:0] low_grp = '0;
    logic         bus_idle = 1'b0;
    logic         txn_start = 1'b0;
    logic [N-1:0] gnt;

    int n_checks = 0;
    int n_fail   = 0;
    string phase = "R1";
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    two_level_arb #(.N_MASTERS(N)) dut (
        .clk(clk), .rst(rst), .req(req), .low_grp(low_grp),
        .bus_idle(bus_idle), .txn_start(txn_start), .gnt(gnt)
    );

    // behavioural reference: integer owner and rotation positions
    int m_gnt = -1;
    int m_hi  = 0;
    int m_lo  = 0;

    function automatic int pick(logic [N-1:0] r, logic [N-1:0] lg, int hpos, int lpos);
        for (int k = 0; k <= N; k++) begin
            int p = (hpos + k) % (N + 1);
            if (p < N) begin
                if (r[p] && !lg[p]) return p;
            end else begin
                for (int j = 0; j < N; j++) begin
                    int q = (lpos + j) % N;
                    if (r[q] && lg[q]) return q;
                end
            end
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_gnt = -1; m_hi = 0; m_lo = 0;
        end else begin
            int w;
            if (txn_start && m_gnt >= 0) begin
                if (low_grp[m_gnt]) begin m_hi = 0; m_lo = (m_gnt + 1) % N; end
                else m_hi = m_gnt + 1;
            end
            w = pick(req, low_grp, m_hi, m_lo);
            if (bus_idle && m_gnt >= 0 && w != m_gnt) m_gnt = -1;
            else m_gnt = w;
        end
    end

    function automatic logic [N-1:0] to_oh(int i);
        return (i < 0) ? '0 : (N'(1) << i);
    endfunction

    function automatic int oh_idx(logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: gnt=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // model compared on every clock (R2, R12 and all ordering rules)
    always @(negedge clk) begin
        if (!rst && !done) begin
            check({phase, " model"}, gnt, to_oh(m_gnt));
            check("R2 one-hot", N'($countones(gnt) <= 1), N'(1));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: cycles=%0d expected<100000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic do_reset(logic [N-1:0] lg);
        @(negedge clk);
        rst = 1'b1; req = '0; txn_start = 1'b0; bus_idle = 1'b0; low_grp = lg;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // collect grants, starting each one as it appears
    task automatic run_seq(string tag, int exp[]);
        foreach (exp[k]) begin
            int got = -1;
            for (int t = 0; t < 8; t++) begin
                @(negedge clk);
                if (gnt != '0) begin got = oh_idx(gnt); break; end
                txn_start = 1'b0;
            end
            n_checks++;
            if (got != exp[k]) begin
                n_fail++;
                $display("FAIL %s: step %0d granted=%0d expected=%0d", tag, k, got, exp[k]);
            end
            txn_start = 1'b1;
        end
        @(negedge clk);
        txn_start = 1'b0;
    endtask

    initial begin
        // R1: reset state
        phase = "R1";
        do_reset(5'b01010);
        @(negedge clk);
        check("R1 reset grant", gnt, '0);
        req = 5'b01010;
        @(negedge clk);
        check("R1 low search from index 0", gnt, 5'b00010);

        // R5 with R3/R4: two classes, master 1 ran last
        phase = "R5";
        do_reset(5'b01010);
        req = 5'b00010;
        run_seq("R5 prime", '{1});
        req = 5'b01111;
        run_seq("R5 order", '{0, 2, 3, 0, 2, 1});

        // R6: master 2 idle, skipped in the high class (R3)
        phase = "R6";
        do_reset(5'b01010);
        req = 5'b00010;
        run_seq("R6 prime", '{1});
        req = 5'b01011;
        run_seq("R6 order", '{0, 3, 0, 1, 0, 3});

        // R7: single class or one low master
        phase = "R7";
        do_reset(5'b00000);
        req = 5'b11111;
        run_seq("R7 all high", '{0, 1, 2, 3, 4, 0});
        do_reset(5'b11111);
        req = 5'b11111;
        run_seq("R7 all low", '{0, 1, 2, 3, 4, 0});
        do_reset(5'b00100);
        req = 5'b11111;
        run_seq("R4 one low master", '{0, 1, 3, 4, 2, 0});

        // R9: pending low grant withdrawn
        phase = "R9";
        do_reset(5'b01010);
        req = 5'b00010;
        run_seq("R9 prime", '{1});
        req = 5'b01001;
        run_seq("R9 start 0", '{0});
        check("R9 pending low grant", gnt, 5'b01000);
        req = 5'b01101;
        @(negedge clk);
        check("R9 moved to master 2", gnt, 5'b00100);

        // R10: turnaround clock while idle
        phase = "R10";
        do_reset(5'b00000);
        bus_idle = 1'b1;
        req = 5'b00001;
        @(negedge clk);
        check("R10 first grant direct", gnt, 5'b00001);
        req = 5'b00010;
        @(negedge clk);
        check("R10 dead clock", gnt, 5'b00000);
        @(negedge clk);
        check("R10 new winner", gnt, 5'b00010);
        bus_idle = 1'b0;
        req = 5'b00001;
        @(negedge clk);
        check("R10 busy bus moves directly", gnt, 5'b00001);

        // R11 and R8: no requests, pointers hold
        phase = "R11";
        do_reset(5'b00000);
        req = 5'b11111;
        run_seq("R11 start 0", '{0});
        req = 5'b00000;
        @(negedge clk);
        check("R11 no request no grant", gnt, '0);
        txn_start = 1'b1;
        repeat (3) @(negedge clk);
        txn_start = 1'b0;
        check("R8 start without grant ignored", gnt, '0);
        req = 5'b11111;
        @(negedge clk);
        check("R11 pointer held", gnt, 5'b00010);
        bus_idle = 1'b0;
        req = 5'b00001;
        @(negedge clk);
        check("R8 no start keeps rotation", gnt, 5'b00001);
        req = 5'b11111;
        @(negedge clk);
        check("R12 R3 resumes at master 1", gnt, 5'b00010);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule